// File: doc/BRIEF.md
# Outstanding Miss Tracker

This block keeps track of cache-line misses that are waiting on the next memory level, so the cache around it can keep running while lines are being fetched. Every accepted miss carries a byte address and a requester tag. A miss to a line that is not already being fetched claims a free entry, and the entry sends out one fetch request. Further misses to that line are added to the entry's waiter list and send out nothing. Lines that differ can be fetched at the same time. Hits are handled somewhere else and never reach this block.

Each fetch leaves with the index of its entry as its transaction identifier. When the fill comes back carrying that identifier, the entry hands back its waiting requester tags one at a time, in the order they arrived. The entry is then released. When no entry is free, or the matching waiter list is already full, the block lowers its ready output, and the requester holds the miss until it is accepted.

Top module: `mshr_file`

## Requirements
- R1: An accepted miss whose line matches no entry in the waiting state claims the lowest-numbered free entry. In the next cycle `fetch_valid` is high for exactly one cycle, and `fetch_id` carries that entry's index.
- R2: An accepted miss whose line matches an entry in the waiting state is added to that entry's waiter list. In the next cycle `fetch_valid` stays low.
- R3: Up to NUM_ENTRIES distinct lines can be outstanding at once, each with its own fetch and its own `fetch_id`.
- R4: `full` is high while every entry is waiting or draining. While `full` is high, a miss to a line that has no waiting entry sees `miss_ready` low and is not taken. An entry becomes free in the cycle after its last waiter is replayed.
- R5: A miss to a waiting line whose list already holds NUM_WAITERS tags sees `miss_ready` low and is not taken.
- R6: If `fill_valid` arrives with the `fill_id` of a waiting entry, then from the next cycle on `replay_valid` is high and the entry's tags come out one per cycle in arrival order. Each replay carries the entry's line on `replay_line` and its index on `replay_id`.
- R7: When more than one entry is draining, the lowest-numbered one replays first, one tag per cycle overall.
- R8: A fill whose `fill_id` names an entry that is not waiting has no effect. No replay follows it.
- R9: A miss to a line in the same cycle as that line's fill is added to the entry as its last waiter. It causes no fetch and is replayed after the earlier tags.
- R10: A miss to a line whose entry is already draining claims a new entry and causes a new fetch.
- R11: After reset, `full`, `fetch_valid` and `replay_valid` are low and `miss_ready` is high.
- R12: The line of a miss is its byte address shifted right by OFFSET_W bits (6 by default, for 64-byte lines). This value is the one that appears on `fetch_line` and `replay_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A miss is presented |
| miss_addr | input | ADDR_W | Byte address of the miss |
| miss_tag | input | TAG_W | Requester tag to return on replay |
| miss_ready | output | 1 | Miss is taken this cycle if valid |
| fetch_valid | output | 1 | One-cycle fetch request to the next level |
| fetch_line | output | ADDR_W-OFFSET_W | Line address to fetch |
| fetch_id | output | clog2(NUM_ENTRIES) | Transaction identifier (entry index) |
| fill_valid | input | 1 | Fill response arrives |
| fill_id | input | clog2(NUM_ENTRIES) | Identifier of the fill |
| replay_valid | output | 1 | A waiter is released this cycle |
| replay_tag | output | TAG_W | Released requester tag |
| replay_line | output | ADDR_W-OFFSET_W | Line of the released waiter |
| replay_id | output | clog2(NUM_ENTRIES) | Entry being drained |
| full | output | 1 | No entry is free |

## Verification
Suppose two entries claim the same line. Then a later miss to that line merges into one of them, and the fetch count comes out one too high. Suppose a waiter count is off by one. Then the replay stream at the ports holds one tag too many or too few, and the entry frees a cycle early or late. That shows on `full` and on the `fetch_id` given to the next miss. Any error in order or arbitration appears in the very next replay cycles as a tag out of place. The bench uses a four-entry, three-waiter configuration. It drives the block to full occupancy, a full waiter list, a fill in the same cycle as a miss, overlapping drains, and a miss during a drain. It compares every replay and fetch cycle by cycle.

// File: rtl/mshr_pkg.sv
package mshr_pkg;

  typedef enum logic [1:0] {
    SLOT_IDLE  = 2'd0,
    SLOT_WAIT  = 2'd1,
    SLOT_DRAIN = 2'd2
  } slot_state_t;

endpackage

// File: rtl/mshr_pick.sv
// Lowest-index priority picker: one-hot grant plus the encoded index.
module mshr_pick #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    logic found;
    grant = '0;
    idx   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        grant[i] = 1'b1;
        idx      = IW'(i);
        found    = 1'b1;
      end
    end
    any = |req;
  end

endmodule

// File: rtl/mshr_entry.sv
// One tracking entry: line address, ordered waiter list, drain pointer.
module mshr_entry
  import mshr_pkg::*;
#(
  parameter int LINE_W  = 26,
  parameter int TAG_W   = 8,
  parameter int WAITERS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              merge_i,
  input  logic              fill_i,
  input  logic              release_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              waiting_o,
  output logic              draining_o,
  output logic              list_full_o,
  output logic [LINE_W-1:0] line_o,
  output logic [TAG_W-1:0]  head_tag_o
);

  localparam int PW = (WAITERS > 1) ? $clog2(WAITERS) : 1;
  localparam int CW = $clog2(WAITERS + 1);

  slot_state_t             state_q;
  logic [LINE_W-1:0]       line_q;
  logic [CW-1:0]           count_q;
  logic [PW-1:0]           ptr_q;
  logic [TAG_W-1:0]        tags_q [WAITERS];
  logic                    at_last;

  // Position of the next free slot in the waiter list.
  function automatic logic [PW-1:0] slot_of(input logic [CW-1:0] n);
    return PW'(n);
  endfunction

  // The head pointer sits on the final recorded waiter.
  function automatic logic is_final(input logic [PW-1:0] p, input logic [CW-1:0] n);
    return (CW'(p) + CW'(1)) == n;
  endfunction

  assign at_last = is_final(ptr_q, count_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SLOT_IDLE;
      line_q  <= '0;
      count_q <= '0;
      ptr_q   <= '0;
    end else if (alloc_i) begin
      state_q <= SLOT_WAIT;
      line_q  <= line_i;
      count_q <= CW'(1);
      ptr_q   <= '0;
    end else begin
      if (merge_i) count_q <= count_q + CW'(1);
      if (fill_i)  state_q <= SLOT_DRAIN;
      if (release_i) begin
        if (at_last) state_q <= SLOT_IDLE;
        else         ptr_q   <= ptr_q + PW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_i)      tags_q[0]                <= tag_i;
    else if (merge_i) tags_q[slot_of(count_q)] <= tag_i;
  end

  assign waiting_o   = (state_q == SLOT_WAIT);
  assign draining_o  = (state_q == SLOT_DRAIN);
  assign list_full_o = (count_q == CW'(WAITERS));
  assign line_o      = line_q;
  assign head_tag_o  = tags_q[ptr_q];

endmodule

// File: rtl/mshr_file.sv
// Outstanding-miss tracker with merging, back-pressure and ordered replay.
module mshr_file #(
  parameter int NUM_ENTRIES = 8,
  parameter int NUM_WAITERS = 4,
  parameter int ADDR_W      = 32,
  parameter int OFFSET_W    = 6,
  parameter int TAG_W       = 8,
  localparam int LINE_W     = ADDR_W - OFFSET_W,
  localparam int ID_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [TAG_W-1:0]  miss_tag,
  output logic              miss_ready,
  output logic              fetch_valid,
  output logic [LINE_W-1:0] fetch_line,
  output logic [ID_W-1:0]   fetch_id,
  input  logic              fill_valid,
  input  logic [ID_W-1:0]   fill_id,
  output logic              replay_valid,
  output logic [TAG_W-1:0]  replay_tag,
  output logic [LINE_W-1:0] replay_line,
  output logic [ID_W-1:0]   replay_id,
  output logic              full
);

  // Byte address to line address.
  function automatic logic [LINE_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFFSET_W];
  endfunction

  logic [LINE_W-1:0]      miss_line;
  logic [NUM_ENTRIES-1:0] waiting_vec, draining_vec, list_full_vec;
  logic [NUM_ENTRIES-1:0] match_vec, free_vec, fill_vec;
  logic [NUM_ENTRIES-1:0] alloc_grant, alloc_vec, merge_vec, release_vec;
  logic [LINE_W-1:0]      ent_line [NUM_ENTRIES];
  logic [TAG_W-1:0]       ent_tag  [NUM_ENTRIES];
  logic [ID_W-1:0]        alloc_idx, rel_idx;
  logic                   free_any, drain_any;
  logic                   any_match, match_full, accept;
  logic                   alloc_any, merge_any;

  assign miss_line = line_of(miss_addr);
  assign free_vec  = ~(waiting_vec | draining_vec);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    assign match_vec[g] = waiting_vec[g] && (ent_line[g] == miss_line);
    assign fill_vec[g]  = fill_valid && (fill_id == ID_W'(g)) && waiting_vec[g];

    mshr_entry #(
      .LINE_W (LINE_W),
      .TAG_W  (TAG_W),
      .WAITERS(NUM_WAITERS)
    ) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_i    (alloc_vec[g]),
      .merge_i    (merge_vec[g]),
      .fill_i     (fill_vec[g]),
      .release_i  (release_vec[g]),
      .line_i     (miss_line),
      .tag_i      (miss_tag),
      .waiting_o  (waiting_vec[g]),
      .draining_o (draining_vec[g]),
      .list_full_o(list_full_vec[g]),
      .line_o     (ent_line[g]),
      .head_tag_o (ent_tag[g])
    );
  end

  mshr_pick #(.N(NUM_ENTRIES), .IW(ID_W)) u_free_pick (
    .req  (free_vec),
    .grant(alloc_grant),
    .idx  (alloc_idx),
    .any  (free_any)
  );

  mshr_pick #(.N(NUM_ENTRIES), .IW(ID_W)) u_drain_pick (
    .req  (draining_vec),
    .grant(release_vec),
    .idx  (rel_idx),
    .any  (drain_any)
  );

  assign any_match  = |match_vec;
  assign match_full = |(match_vec & list_full_vec);
  assign miss_ready = any_match ? !match_full : free_any;
  assign accept     = miss_valid && miss_ready;
  assign alloc_vec  = (accept && !any_match) ? alloc_grant : '0;
  assign merge_vec  = accept ? match_vec : '0;
  assign alloc_any  = |alloc_vec;
  assign merge_any  = |merge_vec;

  assign replay_valid = drain_any;
  assign replay_tag   = ent_tag[rel_idx];
  assign replay_line  = ent_line[rel_idx];
  assign replay_id    = rel_idx;
  assign full         = !free_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_valid <= 1'b0;
      fetch_line  <= '0;
      fetch_id    <= '0;
    end else begin
      fetch_valid <= alloc_any;
      if (alloc_any) begin
        fetch_line <= miss_line;
        fetch_id   <= alloc_idx;
      end
    end
  end

endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         miss_valid,
  input logic         miss_ready,
  input logic         full,
  input logic         fetch_valid,
  input logic         replay_valid,
  input logic         match_full,
  input logic         alloc_any,
  input logic         merge_any,
  input logic [N-1:0] match_vec,
  input logic [N-1:0] alloc_vec,
  input logic [N-1:0] merge_vec,
  input logic [N-1:0] release_vec
);

  a_r1_fetch_after_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_any |=> fetch_valid);

  a_r2_merge_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (merge_any && !alloc_any) |=> !fetch_valid);

  a_r2_unique_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  a_r1_single_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(alloc_vec));

  a_r4_full_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (alloc_vec == '0));

  a_r4_refused_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && !miss_ready) |-> (alloc_vec == '0 && merge_vec == '0));

  a_r5_list_cap: assert property (@(posedge clk) disable iff (!rst_n)
    match_full |-> (merge_vec == '0));

  a_r7_one_release: assert property (@(posedge clk) disable iff (!rst_n)
    replay_valid |-> ($countones(release_vec) == 1));

endmodule

bind mshr_file mshr_file_chk #(.N(NUM_ENTRIES)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .miss_valid  (miss_valid),
  .miss_ready  (miss_ready),
  .full        (full),
  .fetch_valid (fetch_valid),
  .replay_valid(replay_valid),
  .match_full  (match_full),
  .alloc_any   (alloc_any),
  .merge_any   (merge_any),
  .match_vec   (match_vec),
  .alloc_vec   (alloc_vec),
  .merge_vec   (merge_vec),
  .release_vec (release_vec)
);

// File: tb/test_mshr_file.sv
module test_mshr_file;

  localparam int NE  = 4;
  localparam int NW  = 3;
  localparam int AW  = 16;
  localparam int OW  = 6;
  localparam int TW  = 8;
  localparam int LW  = AW - OW;
  localparam int IDW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          miss_valid;
  logic [AW-1:0] miss_addr;
  logic [TW-1:0] miss_tag;
  logic          miss_ready;
  logic          fetch_valid;
  logic [LW-1:0] fetch_line;
  logic [IDW-1:0] fetch_id;
  logic          fill_valid;
  logic [IDW-1:0] fill_id;
  logic          replay_valid;
  logic [TW-1:0] replay_tag;
  logic [LW-1:0] replay_line;
  logic [IDW-1:0] replay_id;
  logic          full;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  mshr_file #(
    .NUM_ENTRIES(NE),
    .NUM_WAITERS(NW),
    .ADDR_W     (AW),
    .OFFSET_W   (OW),
    .TAG_W      (TW)
  ) i_mshr_file (
    .clk         (clk),
    .rst_n       (rst_n),
    .miss_valid  (miss_valid),
    .miss_addr   (miss_addr),
    .miss_tag    (miss_tag),
    .miss_ready  (miss_ready),
    .fetch_valid (fetch_valid),
    .fetch_line  (fetch_line),
    .fetch_id    (fetch_id),
    .fill_valid  (fill_valid),
    .fill_id     (fill_id),
    .replay_valid(replay_valid),
    .replay_tag  (replay_tag),
    .replay_line (replay_line),
    .replay_id   (replay_id),
    .full        (full)
  );

  // Bench-side line numbers and byte addresses with nonzero offsets.
  function automatic logic [LW-1:0] tb_line(input int k);
    return LW'(10'h040 + k * 3);
  endfunction
  function automatic logic [AW-1:0] tb_addr(input int k);
    return (AW'(tb_line(k)) * AW'(64)) + AW'((k * 7 + 1) % 64);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
    fill_valid = 1'b0;
  endtask

  task automatic put_miss(input int k, input int tag);
    miss_valid = 1'b1;
    miss_addr  = tb_addr(k);
    miss_tag   = TW'(tag);
    #1;
  endtask

  task automatic put_fill(input int id);
    fill_valid = 1'b1;
    fill_id    = IDW'(id);
    #1;
  endtask

  task automatic exp_replay(input string req, input int tag, input int k, input int id);
    chk({req, " replay_valid"}, 32'(replay_valid), 32'd1);
    chk({req, " replay_tag"},   32'(replay_tag),   32'(tag));
    chk({req, " replay_line"},  32'(replay_line),  32'(tb_line(k)));
    chk({req, " replay_id"},    32'(replay_id),    32'(id));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    miss_valid = 1'b0;
    miss_addr  = '0;
    miss_tag   = '0;
    fill_valid = 1'b0;
    fill_id    = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R11: reset state
    chk("R11 full",         32'(full),         32'd0);
    chk("R11 fetch_valid",  32'(fetch_valid),  32'd0);
    chk("R11 replay_valid", 32'(replay_valid), 32'd0);
    chk("R11 miss_ready",   32'(miss_ready),   32'd1);

    // R1 R3 R12: fill every entry with a distinct line
    for (int k = 0; k < NE; k++) begin
      put_miss(k, k);
      chk("R3 ready before full", 32'(miss_ready), 32'd1);
      tick();
      chk("R1 fetch_valid", 32'(fetch_valid), 32'd1);
      chk("R3 fetch_id",    32'(fetch_id),    32'(k));
      chk("R12 fetch_line", 32'(fetch_line),  32'(tb_line(k)));
      chk("R4 full level",  32'(full),        32'(k == NE - 1));
      tick();
      chk("R1 single fetch", 32'(fetch_valid), 32'd0);
    end

    // R4: new line refused when full
    put_miss(9, 77);
    chk("R4 ready when full", 32'(miss_ready), 32'd0);
    tick();
    chk("R4 no fetch when full", 32'(fetch_valid), 32'd0);

    // R2: merges to line 0 until the list holds NW tags
    for (int m = 1; m < NW; m++) begin
      put_miss(0, 99 + m);
      chk("R2 merge ready", 32'(miss_ready), 32'd1);
      tick();
      chk("R2 merge no fetch", 32'(fetch_valid), 32'd0);
    end
    // R5: list full
    put_miss(0, 120);
    chk("R5 list full refused", 32'(miss_ready), 32'd0);
    tick();

    // R6: fill entry 0, replay in order 0,100,101
    put_fill(0);
    tick();
    exp_replay("R6 first", 0, 0, 0);
    chk("R4 full during drain", 32'(full), 32'd1);
    tick();
    exp_replay("R6 second", 100, 0, 0);
    tick();
    exp_replay("R6 third", 101, 0, 0);
    chk("R4 still held on last", 32'(full), 32'd1);
    tick();
    chk("R6 drain ends", 32'(replay_valid), 32'd0);
    chk("R4 freed after last", 32'(full), 32'd0);

    // R8: fill for a free entry is ignored
    put_fill(0);
    tick();
    chk("R8 no replay", 32'(replay_valid), 32'd0);
    tick();
    chk("R8 still none", 32'(replay_valid), 32'd0);

    // R9: miss and fill on line 1 in the same cycle
    put_fill(1);
    put_miss(1, 50);
    chk("R9 ready", 32'(miss_ready), 32'd1);
    tick();
    chk("R9 no fetch", 32'(fetch_valid), 32'd0);
    exp_replay("R9 earlier tag", 1, 1, 1);
    tick();
    exp_replay("R9 joined tag last", 50, 1, 1);
    tick();
    chk("R9 drain ends", 32'(replay_valid), 32'd0);

    // R7: overlapping drains, lower index wins
    put_miss(3, 30);
    tick();
    put_miss(3, 31);
    tick();
    put_fill(3);
    tick();
    exp_replay("R7 entry3 alone", 3, 3, 3);
    put_fill(2);
    tick();
    exp_replay("R7 lower index first", 2, 2, 2);
    tick();
    exp_replay("R7 entry3 resumes", 30, 3, 3);
    tick();
    exp_replay("R7 entry3 last", 31, 3, 3);
    tick();
    chk("R7 all drained", 32'(replay_valid), 32'd0);
    chk("R7 none full",   32'(full),         32'd0);

    // R10: miss to a draining line takes a new entry
    put_miss(5, 60);
    tick();
    chk("R10 first fetch", 32'(fetch_valid), 32'd1);
    chk("R10 first id",    32'(fetch_id),    32'd0);
    put_miss(5, 61);
    tick();
    put_fill(0);
    tick();
    exp_replay("R10 drain head", 60, 5, 0);
    put_miss(5, 62);
    chk("R10 ready during drain", 32'(miss_ready), 32'd1);
    tick();
    chk("R10 new fetch",      32'(fetch_valid), 32'd1);
    chk("R10 new id",         32'(fetch_id),    32'd1);
    chk("R10 new fetch line", 32'(fetch_line),  32'(tb_line(5)));
    exp_replay("R10 old entry continues", 61, 5, 0);
    tick();
    chk("R10 old drained", 32'(replay_valid), 32'd0);
    put_fill(1);
    tick();
    exp_replay("R10 new entry replay", 62, 5, 1);
    tick();
    chk("R10 end", 32'(replay_valid), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule